// File: doc/BRIEF.md
# Circular buffer address generator

This unit computes addresses for load and store operations that use a pointer register. Each request names one of eight pointer slots, supplies the current pointer value and an unsigned offset, and says whether the offset is added or subtracted and whether the pointer changes before or after the access. The unit returns the address to access and the new pointer value. The pointer file writes that value back one cycle after the request. This timing does not depend on how long the memory access itself takes.

A per-slot mode field, held on a static configuration input, chooses plain linear arithmetic or circular arithmetic for each slot. In circular arithmetic the buffer is a power-of-two block, 2^k bytes, aligned to its own size. The pointer wraps inside that block, and only its low k bits change. Two shared size inputs each give an exponent k. Every circular slot uses one of the two, so all eight slots can run circular buffers at the same time, with no more than two distinct sizes between them.

Top module: `circ_agu`

## Requirements
- R1: While reset is held low, and in the first cycle after it, out_valid, out_ea, out_wb_ptr and out_wb_idx are all zero.
- R2: A slot whose mode field is 2'b00 or 2'b11 is linear: the new pointer is req_ptr + req_off when req_dec is 0, and req_ptr - req_off when it is 1, both modulo 2^ADDR_W.
- R3: Mode field 2'b01 selects circular arithmetic with exponent size_a_log. Mode field 2'b10 selects circular arithmetic with exponent size_b_log.
- R4: In circular arithmetic with exponent k, bits k and above of the new pointer equal those of req_ptr. The low k bits equal (low k bits of req_ptr ± req_off) mod 2^k.
- R5: A circular decrement that crosses the block start lands at the block end, and a circular increment past the block end lands at the block start. The same holds for offsets larger than the block.
- R6: With req_pre = 1, out_ea equals the new pointer.
- R7: With req_pre = 0, out_ea equals the original req_ptr.
- R8: A request accepted with req_valid = 1 on one rising edge produces out_valid = 1 after the next edge, with out_wb_idx = req_idx. Requests can issue every cycle. A cycle without req_valid gives out_valid = 0.
- R9: The mode field of slot i sits at mode_cfg[2i+1:2i], and each slot is decoded independently of the others.
- R10: A circular slot whose exponent is 0, a block of one location, leaves the pointer unchanged for any offset and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cfg | input | 2*NUM_PTR | Mode field per pointer slot |
| size_a_log | input | LOG_W | Exponent of the first block size |
| size_b_log | input | LOG_W | Exponent of the second block size |
| req_valid | input | 1 | Request present this cycle |
| req_idx | input | IDX_W | Pointer slot of the request |
| req_ptr | input | ADDR_W | Current pointer value |
| req_off | input | ADDR_W | Unsigned offset magnitude |
| req_dec | input | 1 | 1 subtracts the offset, 0 adds it |
| req_pre | input | 1 | 1 modifies the pointer before the access, 0 after it |
| out_valid | output | 1 | Result present |
| out_ea | output | ADDR_W | Address to access |
| out_wb_ptr | output | ADDR_W | Updated pointer for write-back |
| out_wb_idx | output | IDX_W | Slot to write back |

## Verification
Linear slots are driven across zero in both directions, which separates true modulo-2^ADDR_W arithmetic from any masking. Circular slots of both sizes are driven at the block start, at the block end and with offsets larger than the block, which separates a masked wrap from a carry or borrow that leaks into the fixed upper bits. Pre-modify and post-modify runs use the same pointer and offset, so the two address choices are compared on equal inputs. A back-to-back sweep over all eight slots exposes errors in the slot-to-field mapping. A run with exponent 0 exposes an off-by-one in mask generation.

// File: rtl/circ_agu_pkg.sv
package circ_agu_pkg;

  typedef enum logic [1:0] {
    AM_LINEAR = 2'b00,
    AM_CIRC_A = 2'b01,
    AM_CIRC_B = 2'b10,
    AM_RSVD   = 2'b11
  } addr_mode_e;

endpackage

// File: rtl/circ_agu_mode_sel.sv
module circ_agu_mode_sel
  import circ_agu_pkg::*;
#(
  parameter  int ADDR_W  = 32,
  parameter  int NUM_PTR = 8,
  localparam int IDX_W   = $clog2(NUM_PTR),
  localparam int LOG_W   = $clog2(ADDR_W)
) (
  input  logic [2*NUM_PTR-1:0] mode_cfg,
  input  logic [IDX_W-1:0]     idx,
  input  logic [LOG_W-1:0]     size_a_log,
  input  logic [LOG_W-1:0]     size_b_log,
  output logic                 circ_en,
  output logic [ADDR_W-1:0]    wrap_mask
);

  addr_mode_e slot_mode [NUM_PTR];

  genvar g;
  generate
    for (g = 0; g < NUM_PTR; g++) begin : g_slot
      assign slot_mode[g] = addr_mode_e'(mode_cfg[2*g+1 : 2*g]);
    end
  endgenerate

  function automatic logic [ADDR_W-1:0] low_mask(input logic [LOG_W-1:0] k);
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i < int'(k));
    return m;
  endfunction

  addr_mode_e cur_mode;
  logic [LOG_W-1:0] cur_log;

  always_comb begin
    cur_mode = slot_mode[idx];
    circ_en  = 1'b0;
    cur_log  = '0;
    unique case (cur_mode)
      AM_CIRC_A: begin circ_en = 1'b1; cur_log = size_a_log; end
      AM_CIRC_B: begin circ_en = 1'b1; cur_log = size_b_log; end
      default:   begin circ_en = 1'b0; cur_log = '0; end
    endcase
    wrap_mask = circ_en ? low_mask(cur_log) : '1;
  end

endmodule

// File: rtl/circ_agu_calc.sv
module circ_agu_calc #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] off,
  input  logic              dec,
  input  logic              pre,
  input  logic [ADDR_W-1:0] wrap_mask,
  output logic [ADDR_W-1:0] next_ptr,
  output logic [ADDR_W-1:0] ea,
  output logic              wrap_evt
);

  function automatic logic [ADDR_W-1:0] raw_step(
    input logic [ADDR_W-1:0] p, input logic [ADDR_W-1:0] o, input logic d);
    return d ? (p - o) : (p + o);
  endfunction

  function automatic logic [ADDR_W-1:0] merge_field(
    input logic [ADDR_W-1:0] keep, input logic [ADDR_W-1:0] fresh,
    input logic [ADDR_W-1:0] m);
    return (keep & ~m) | (fresh & m);
  endfunction

  logic [ADDR_W-1:0] sum;

  always_comb begin
    sum      = raw_step(ptr, off, dec);
    next_ptr = merge_field(ptr, sum, wrap_mask);
    ea       = pre ? next_ptr : ptr;
    wrap_evt = ((sum ^ ptr) & ~wrap_mask) != '0;
  end

endmodule

// File: rtl/circ_agu.sv
module circ_agu
  import circ_agu_pkg::*;
#(
  parameter  int ADDR_W  = 32,
  parameter  int NUM_PTR = 8,
  localparam int IDX_W   = $clog2(NUM_PTR),
  localparam int LOG_W   = $clog2(ADDR_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*NUM_PTR-1:0] mode_cfg,
  input  logic [LOG_W-1:0]     size_a_log,
  input  logic [LOG_W-1:0]     size_b_log,
  input  logic                 req_valid,
  input  logic [IDX_W-1:0]     req_idx,
  input  logic [ADDR_W-1:0]    req_ptr,
  input  logic [ADDR_W-1:0]    req_off,
  input  logic                 req_dec,
  input  logic                 req_pre,
  output logic                 out_valid,
  output logic [ADDR_W-1:0]    out_ea,
  output logic [ADDR_W-1:0]    out_wb_ptr,
  output logic [IDX_W-1:0]     out_wb_idx
);

  logic              sel_circ;
  logic [ADDR_W-1:0] sel_mask;
  logic [ADDR_W-1:0] calc_next;
  logic [ADDR_W-1:0] calc_ea;
  logic              calc_wrap;

  circ_agu_mode_sel #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR)) u_sel (
    .mode_cfg   (mode_cfg),
    .idx        (req_idx),
    .size_a_log (size_a_log),
    .size_b_log (size_b_log),
    .circ_en    (sel_circ),
    .wrap_mask  (sel_mask)
  );

  circ_agu_calc #(.ADDR_W(ADDR_W)) u_calc (
    .ptr       (req_ptr),
    .off       (req_off),
    .dec       (req_dec),
    .pre       (req_pre),
    .wrap_mask (sel_mask),
    .next_ptr  (calc_next),
    .ea        (calc_ea),
    .wrap_evt  (calc_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_ea     <= '0;
      out_wb_ptr <= '0;
      out_wb_idx <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_ea     <= calc_ea;
        out_wb_ptr <= calc_next;
        out_wb_idx <= req_idx;
      end
    end
  end

endmodule

// File: rtl/circ_agu_chk.sv
module circ_agu_chk #(
  parameter  int ADDR_W  = 32,
  parameter  int NUM_PTR = 8,
  localparam int IDX_W   = $clog2(NUM_PTR)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [IDX_W-1:0]  req_idx,
  input logic [ADDR_W-1:0] req_ptr,
  input logic [ADDR_W-1:0] req_off,
  input logic              req_dec,
  input logic              req_pre,
  input logic              sel_circ,
  input logic [ADDR_W-1:0] sel_mask,
  input logic              calc_wrap,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_ea,
  input logic [ADDR_W-1:0] out_wb_ptr,
  input logic [IDX_W-1:0]  out_wb_idx
);

  a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  a_r8_idx_echo: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_wb_idx == $past(req_idx));

  a_r2_linear_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sel_circ) |=>
      out_wb_ptr == ($past(req_dec) ? $past(req_ptr) - $past(req_off)
                                    : $past(req_ptr) + $past(req_off)));

  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel_circ) |=>
      ((out_wb_ptr ^ $past(req_ptr)) & ~$past(sel_mask)) == '0);

  a_r5_wrap_stays_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel_circ && calc_wrap) |=>
      ((out_wb_ptr ^ $past(req_ptr)) & ~$past(sel_mask)) == '0);

  a_r6_pre_uses_new: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_pre) |=> out_ea == out_wb_ptr);

  a_r7_post_uses_old: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_pre) |=> out_ea == $past(req_ptr));

  a_r10_unit_block: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel_circ && sel_mask == '0) |=> out_wb_ptr == $past(req_ptr));

endmodule

bind circ_agu circ_agu_chk #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_idx    (req_idx),
  .req_ptr    (req_ptr),
  .req_off    (req_off),
  .req_dec    (req_dec),
  .req_pre    (req_pre),
  .sel_circ   (sel_circ),
  .sel_mask   (sel_mask),
  .calc_wrap  (calc_wrap),
  .out_valid  (out_valid),
  .out_ea     (out_ea),
  .out_wb_ptr (out_wb_ptr),
  .out_wb_idx (out_wb_idx)
);

// File: tb/circ_agu_test.sv
module circ_agu_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NP = 8;
  localparam int IW = 3;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2*NP-1:0] mode_cfg = '0;
  logic [LW-1:0] size_a_log = '0;
  logic [LW-1:0] size_b_log = '0;
  logic          req_valid = 1'b0;
  logic [IW-1:0] req_idx = '0;
  logic [AW-1:0] req_ptr = '0;
  logic [AW-1:0] req_off = '0;
  logic          req_dec = 1'b0;
  logic          req_pre = 1'b0;
  logic          out_valid;
  logic [AW-1:0] out_ea;
  logic [AW-1:0] out_wb_ptr;
  logic [IW-1:0] out_wb_idx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [AW-1:0] ea;
    logic [AW-1:0] wb;
    logic [IW-1:0] idx;
    string         tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_agu uut (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg),
    .size_a_log(size_a_log), .size_b_log(size_b_log),
    .req_valid(req_valid), .req_idx(req_idx), .req_ptr(req_ptr),
    .req_off(req_off), .req_dec(req_dec), .req_pre(req_pre),
    .out_valid(out_valid), .out_ea(out_ea),
    .out_wb_ptr(out_wb_ptr), .out_wb_idx(out_wb_idx)
  );

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: block base plus the offset position taken modulo the block size.
  function automatic logic [AW-1:0] model_next(logic [AW-1:0] p, logic [AW-1:0] o,
                                               logic d, logic [1:0] mf);
    longint unsigned size, base, lo, om, nl;
    int k;
    if (mf == 2'b01) k = int'(size_a_log);
    else if (mf == 2'b10) k = int'(size_b_log);
    else return d ? p - o : p + o;
    size = 64'd1 << k;
    lo   = longint'(p) % size;
    base = longint'(p) - lo;
    om   = longint'(o) % size;
    nl   = d ? (lo + size - om) % size : (lo + om) % size;
    return AW'(base + nl);
  endfunction

  task automatic send(int idx, logic [AW-1:0] p, logic [AW-1:0] o,
                      logic d, logic pre, string tag);
    exp_t e;
    logic [1:0] mf;
    @(negedge clk);
    mf = mode_cfg[2*idx +: 2];
    e.wb  = model_next(p, o, d, mf);
    e.ea  = pre ? e.wb : p;
    e.idx = IW'(idx);
    e.tag = tag;
    sb.push_back(e);
    req_valid = 1'b1; req_idx = IW'(idx); req_ptr = p;
    req_off = o; req_dec = d; req_pre = pre;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: one sample per cycle, just after the edge.
  always begin
    @(posedge clk);
    #1;
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check("R8 spurious out_valid", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " wb_ptr"}, out_wb_ptr, e.wb);
          check({e.tag, " ea"}, out_ea, e.ea);
          check("R8 wb_idx", AW'(out_wb_idx), AW'(e.idx));
        end
      end else if (sb.size() != 0) begin
        check("R8 missing out_valid", 32'd0, 32'd1);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9 slot fields: 0 lin, 1 A, 2 B, 3 rsvd(lin), 4 A, 5 B, 6 A, 7 lin
    mode_cfg   = 16'h19E4;
    size_a_log = 5'd4;
    size_b_log = 5'd8;
    repeat (3) @(posedge clk);
    #2;
    check("R1 out_valid in reset", AW'(out_valid), 32'd0);
    check("R1 out_wb_ptr in reset", out_wb_ptr, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check("R1 out_valid after reset", AW'(out_valid), 32'd0);
    check("R1 out_ea after reset", out_ea, 32'd0);

    send(0, 32'h0000_1000, 32'h10, 1'b0, 1'b0, "R2 linear inc");
    send(0, 32'h0000_0000, 32'h1, 1'b1, 1'b1, "R2 linear dec through zero");
    send(7, 32'hFFFF_FFF0, 32'h20, 1'b0, 1'b1, "R2 linear inc through top");
    send(3, 32'h0000_4000, 32'h8, 1'b1, 1'b0, "R2 reserved mode is linear");
    send(1, 32'h0000_100F, 32'h1, 1'b0, 1'b0, "R5 inc wraps end to start");
    send(1, 32'h0000_1000, 32'h1, 1'b1, 1'b0, "R5 dec wraps start to end");
    send(4, 32'hABCD_1234, 32'h23, 1'b0, 1'b1, "R5 offset larger than block");
    send(2, 32'h2345_67F0, 32'h20, 1'b0, 1'b1, "R4 size B upper fixed");
    send(5, 32'h2345_6705, 32'h10, 1'b1, 1'b0, "R3 size B dec");
    send(6, 32'h0000_0FF8, 32'h4, 1'b0, 1'b1, "R3 size A no wrap");
    send(1, 32'h0000_2006, 32'h5, 1'b0, 1'b1, "R6 pre-modify ea");
    send(1, 32'h0000_2006, 32'h5, 1'b0, 1'b0, "R7 post-modify ea");
    idle();
    @(posedge clk);
    #2;
    check("R8 idle gives no result", AW'(out_valid), 32'd0);

    for (int i = 0; i < NP; i++)
      send(i, 32'h5000_00FE + 32'(i), 32'h3 + 32'(i), i[0], i[1], "R9 slot sweep");
    idle();
    repeat (2) @(negedge clk);

    size_b_log = 5'd0;
    send(2, 32'h1234_5678, 32'h7, 1'b0, 1'b1, "R10 unit block inc");
    send(5, 32'h8765_4321, 32'hFFFF, 1'b1, 1'b0, "R10 unit block dec");
    idle();
    repeat (2) @(negedge clk);

    size_a_log = 5'd31;
    send(4, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1, "R4 largest block keeps top bit");
    idle();
    repeat (3) @(negedge clk);

    done = 1'b1;
    check("R8 all results delivered", 32'(sb.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule